// File: doc/BRIEF.md
# Four-Lane Flag-Steered Integer ALU

This block is a four-lane, 32-bit integer arithmetic unit for a fixed-point vector datapath that emulates floating-point arithmetic in software. Besides plain add, subtract, shift-left and arithmetic shift-right, it offers two steered operations. Each one reads the stored negative flag left by an earlier arithmetic instruction. A steered add/subtract becomes a single add or a single subtract. A steered shift becomes a single left or right shift. Exponent alignment and normalisation therefore need no compare-and-branch sequence.

A four-bit status register holds negative, zero, carry and overflow, taken from lane x (bits [31:0]). Every instruction carries a four-bit condition field that is tested against that register. A failing instruction leaves the result and the flags untouched. Three per-lane compare operations return fixed-point 1.0 or 0, so if/then/else can be written without branches. An instruction presented with `op_valid` is evaluated in that cycle, and its result appears on the registered outputs one clock later.

Top module: `negsel_simd_alu`

## Requirements
- R1: While `rst_n` is low, `flags`, `res_data`, `res_valid` and `res_wr` are all zero.
- R2: Opcode values: 0 ADD, 1 SUB, 2 steered add/sub, 3 LSL, 4 ASR, 5 steered shift, 6 SLT, 7 SGE, 8 SEQ. Values 9 to 15 are reserved. ADD and SUB work per lane, modulo 2^32. Lane i occupies bits [32i+31:32i]. The result appears on `res_data` one cycle after `op_valid`, with `res_valid` high.
- R3: `flags` is {N,Z,C,V} with N in bit 3 and V in bit 0. The flags are taken from lane x only, and only by opcodes 0, 1 and 2. N is the result's bit 31 and Z is set when the result is zero. For an add, C is the carry out. For a subtract, C is set when there is no borrow. V is signed overflow.
- R4: The steered add/sub adds when the stored N is 0 and subtracts when it is 1.
- R5: LSL shifts left with zero fill. ASR shifts right with sign fill. Each lane shifts by bits [4:0] of its own b lane.
- R6: The steered shift is a logical right shift when the stored N is 0 and a left shift when it is 1. The amount is taken as in R5.
- R7: SLT, SGE and SEQ compare each lane as signed values. They write 0x0001_0000 when the test is true and 0 when it is false.
- R8: The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never.
- R9: An instruction whose condition fails gives `res_wr` low one cycle later. It changes neither `res_data` nor `flags`. A cycle without `op_valid` also gives `res_valid` and `res_wr` low.
- R10: Shifts, compares and reserved opcodes leave `flags` unchanged. A reserved opcode never asserts `res_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| op_code | input | 4 | Operation select |
| op_cond | input | 4 | Condition field |
| src_a | input | 128 | Operand A, four lanes |
| src_b | input | 128 | Operand B or shift amounts, four lanes |
| res_valid | output | 1 | An instruction was evaluated in the previous cycle |
| res_wr | output | 1 | That instruction passed its condition and wrote |
| res_data | output | 128 | Last written result |
| flags | output | 4 | Status {N,Z,C,V} |

## Verification
The hardest cases to reach are the steered operations and the conditional codes, because each depends on flags left by an earlier instruction. The stimulus is a chained table. Each entry leaves the flags the next entry needs: a subtract that borrows sets N ahead of a steered subtract, a zero result sets Z ahead of an NE/EQ pair, and a double-minimum add sets C and V ahead of the signed codes. Suppressed and reserved entries expect the previous result and flags to persist.

// File: rtl/negsel_alu_pkg.sv
package negsel_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_SAS = 4'd2,
      OP_LSL = 4'd3,
      OP_ASR = 4'd4,
      OP_SSH = 4'd5,
      OP_SLT = 4'd6,
      OP_SGE = 4'd7,
      OP_SEQ = 4'd8
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } stat_t;

   function automatic logic op_sets_flags(input logic [3:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SAS);
   endfunction

   function automatic logic op_known(input logic [3:0] op);
      return op <= OP_SEQ;
   endfunction

   function automatic logic op_is_cmp(input logic [3:0] op);
      return (op == OP_SLT) || (op == OP_SGE) || (op == OP_SEQ);
   endfunction

endpackage

// File: rtl/negsel_cond_eval.sv
module negsel_cond_eval
   import negsel_alu_pkg::*;
(
   input  stat_t       st,
   input  logic [3:0]  cond,
   output logic        pass
);
   always_comb begin
      unique case (cond)
         4'h0: pass = st.z;
         4'h1: pass = !st.z;
         4'h2: pass = st.c;
         4'h3: pass = !st.c;
         4'h4: pass = st.n;
         4'h5: pass = !st.n;
         4'h6: pass = st.v;
         4'h7: pass = !st.v;
         4'h8: pass = st.c && !st.z;
         4'h9: pass = !st.c || st.z;
         4'hA: pass = (st.n == st.v);
         4'hB: pass = (st.n != st.v);
         4'hC: pass = !st.z && (st.n == st.v);
         4'hD: pass = st.z || (st.n != st.v);
         4'hE: pass = 1'b1;
         default: pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/negsel_lane.sv
module negsel_lane
   import negsel_alu_pkg::*;
#(
   parameter int LANE_W = 32,
   parameter int FRAC_W = 16
) (
   input  logic [3:0]        op,
   input  logic              neg_flag,
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   output logic [LANE_W-1:0] res,
   output logic              c_out,
   output logic              v_out
);
   localparam int SH_W = $clog2(LANE_W);
   localparam logic [LANE_W-1:0] FX_ONE = LANE_W'(1) << FRAC_W;

   logic              do_sub;
   logic [LANE_W:0]   sum;
   logic [LANE_W-1:0] b_eff;
   logic [SH_W-1:0]   shamt;
   logic [LANE_W-1:0] shl, shr_log, shr_ari;
   logic              lt, eq;

   assign do_sub  = (op == OP_SUB) || ((op == OP_SAS) && neg_flag);
   assign b_eff   = do_sub ? ~b : b;
   assign sum     = {1'b0, a} + {1'b0, b_eff} + {{LANE_W{1'b0}}, do_sub};
   assign c_out   = sum[LANE_W];
   assign v_out   = (a[LANE_W-1] == b_eff[LANE_W-1]) && (sum[LANE_W-1] != a[LANE_W-1]);

   assign shamt   = b[SH_W-1:0];
   assign shl     = a << shamt;
   assign shr_log = a >> shamt;
   assign shr_ari = LANE_W'($signed(a) >>> shamt);

   assign lt = $signed(a) < $signed(b);
   assign eq = (a == b);

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_SAS: res = sum[LANE_W-1:0];
         OP_LSL:                 res = shl;
         OP_ASR:                 res = shr_ari;
         OP_SSH:                 res = neg_flag ? shl : shr_log;
         OP_SLT:                 res = lt  ? FX_ONE : '0;
         OP_SGE:                 res = !lt ? FX_ONE : '0;
         OP_SEQ:                 res = eq  ? FX_ONE : '0;
         default:                res = '0;
      endcase
   end
endmodule

// File: rtl/negsel_simd_alu.sv
module negsel_simd_alu
   import negsel_alu_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   parameter int FRAC_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     op_valid,
   input  logic [3:0]               op_code,
   input  logic [3:0]               op_cond,
   input  logic [LANES*LANE_W-1:0]  src_a,
   input  logic [LANES*LANE_W-1:0]  src_b,
   output logic                     res_valid,
   output logic                     res_wr,
   output logic [LANES*LANE_W-1:0]  res_data,
   output logic [3:0]               flags
);
   localparam int DW = LANES * LANE_W;
   localparam logic [LANE_W-1:0] FX_ONE = LANE_W'(1) << FRAC_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < FRAC_W + 2) begin : g_bad_frac
      $error("LANE_W must exceed FRAC_W by at least 2");
   end
   if ((LANE_W & (LANE_W - 1)) != 0) begin : g_bad_width
      $error("LANE_W must be a power of two");
   end

   stat_t             st_q;
   logic [DW-1:0]     res_q;
   logic              vld_q, wr_q;
   logic              cond_ok, issue;
   logic [DW-1:0]     lane_res;
   logic [LANES-1:0]  lane_c, lane_v;

   negsel_cond_eval u_cond (
      .st   (st_q),
      .cond (op_cond),
      .pass (cond_ok)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      negsel_lane #(.LANE_W(LANE_W), .FRAC_W(FRAC_W)) u_lane (
         .op       (op_code),
         .neg_flag (st_q.n),
         .a        (src_a[i*LANE_W +: LANE_W]),
         .b        (src_b[i*LANE_W +: LANE_W]),
         .res      (lane_res[i*LANE_W +: LANE_W]),
         .c_out    (lane_c[i]),
         .v_out    (lane_v[i])
      );
   end

   logic unused_lane_flags;
   assign unused_lane_flags = ^{lane_c, lane_v};

   assign issue = op_valid && cond_ok && op_known(op_code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= '0;
         res_q <= '0;
         vld_q <= 1'b0;
         wr_q  <= 1'b0;
      end else begin
         vld_q <= op_valid;
         wr_q  <= issue;
         if (issue) begin
            res_q <= lane_res;
         end
         if (issue && op_sets_flags(op_code)) begin
            st_q.n <= lane_res[LANE_W-1];
            st_q.z <= (lane_res[LANE_W-1:0] == '0);
            st_q.c <= lane_c[0];
            st_q.v <= lane_v[0];
         end
      end
   end

   assign res_valid = vld_q;
   assign res_wr    = wr_q;
   assign res_data  = res_q;
   assign flags     = st_q;

   // R10 / R9: flags move only after a passing flag-setting instruction
   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && cond_ok && op_sets_flags(op_code)) |=> $stable(flags));

   p_never_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_cond == 4'hF) |=> !res_wr);

   p_wr_has_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr |-> res_valid);

   p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && cond_ok) |=> $stable(res_data));

   p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cond_ok && op_sets_flags(op_code))
         |=> (flags[2] == (res_data[LANE_W-1:0] == '0)));

   p_cmp_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cond_ok && op_is_cmp(op_code))
         |=> (res_data[LANE_W-1:0] == '0 || res_data[LANE_W-1:0] == FX_ONE));

endmodule

// File: tb/negsel_simd_alu_tb_top.sv
module negsel_simd_alu_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0]   req;
      logic [3:0]   op;
      logic [3:0]   cond;
      logic [127:0] a;
      logic [127:0] b;
      logic [127:0] exp;
      logic         wr;
      logic [3:0]   fl;
   } vec_t;

   localparam int NV = 21;
   // lanes written {w,z,y,x}; entries chain through the flags
   localparam vec_t TBL [NV] = '{
      // R2 add, lane wrap
      '{4'd2, 4'd0, 4'hE, {32'h00010000,32'h7FFFFFFF,32'hFFFFFFFF,32'h00000005},
        {32'h00010000,32'h00000001,32'h00000001,32'h00000003},
        {32'h00020000,32'h80000000,32'h00000000,32'h00000008}, 1'b1, 4'h0},
      // R3 sub with borrow: N set, C clear
      '{4'd3, 4'd1, 4'hE, {32'h80000000,32'h00000000,32'h0000000A,32'h00000003},
        {32'h00000001,32'h00000000,32'h00000004,32'h00000005},
        {32'h7FFFFFFF,32'h00000000,32'h00000006,32'hFFFFFFFE}, 1'b1, 4'h8},
      // R4 steered, N=1 -> subtract
      '{4'd4, 4'd2, 4'hE, {32'h0,32'h7,32'h1,32'h64},
        {32'h0,32'h7,32'h2,32'h64},
        {32'h0,32'h0,32'hFFFFFFFF,32'h0}, 1'b1, 4'h6},
      // R4 steered, N=0 -> add, signed overflow
      '{4'd4, 4'd2, 4'hE, {32'hFFFFFFFF,32'h0,32'h1,32'h7FFFFFFF},
        {32'h1,32'h0,32'h2,32'h1},
        {32'h0,32'h0,32'h3,32'h80000000}, 1'b1, 4'h9},
      // R6 steered shift, N=1 -> left
      '{4'd6, 4'd5, 4'hE, {32'h12345678,32'h000000F0,32'h80000001,32'h00000001},
        {32'h0,32'h24,32'h1,32'h4},
        {32'h12345678,32'h00000F00,32'h00000002,32'h00000010}, 1'b1, 4'h9},
      // R8 MI passes
      '{4'd8, 4'd1, 4'h4, {32'h5,32'h0,32'h9,32'h10},
        {32'h5,32'h1,32'h2,32'h10},
        {32'h0,32'hFFFFFFFF,32'h7,32'h0}, 1'b1, 4'h6},
      // R6 steered shift, N=0 -> logical right
      '{4'd6, 4'd5, 4'hE, {32'h100,32'hFFFFFFFF,32'hF0,32'h80000000},
        {32'h0,32'h1F,32'h4,32'h4},
        {32'h100,32'h1,32'hF,32'h08000000}, 1'b1, 4'h6},
      // R5 arithmetic right
      '{4'd5, 4'd4, 4'hE, {32'h7FFFFFFF,32'hFFFFFFF0,32'h40,32'h80000000},
        {32'h1F,32'h2,32'h2,32'h4},
        {32'h0,32'hFFFFFFFC,32'h10,32'hF8000000}, 1'b1, 4'h6},
      // R5 left, amount uses low five bits
      '{4'd5, 4'd3, 4'hE, {32'h0,32'hFFFFFFFF,32'h3,32'h1},
        {32'h5,32'h20,32'h1,32'h1F},
        {32'h0,32'hFFFFFFFF,32'h6,32'h80000000}, 1'b1, 4'h6},
      // R7 SLT
      '{4'd7, 4'd6, 4'hE, {32'h80000000,32'h2,32'h5,32'hFFFFFFFF},
        {32'h7FFFFFFF,32'h80000000,32'h5,32'h0},
        {32'h10000,32'h0,32'h0,32'h10000}, 1'b1, 4'h6},
      // R7 SGE
      '{4'd7, 4'd7, 4'hE, {32'h80000000,32'h2,32'h5,32'hFFFFFFFF},
        {32'h7FFFFFFF,32'h80000000,32'h5,32'h0},
        {32'h0,32'h10000,32'h10000,32'h0}, 1'b1, 4'h6},
      // R7 SEQ
      '{4'd7, 4'd8, 4'hE, {32'hFFFFFFFF,32'h0,32'h7,32'h7},
        {32'h7FFFFFFF,32'h0,32'h8,32'h7},
        {32'h0,32'h10000,32'h0,32'h10000}, 1'b1, 4'h6},
      // R9 NE fails with Z set: nothing changes
      '{4'd9, 4'd0, 4'h1, {4{32'h1}}, {4{32'h1}},
        {32'h0,32'h10000,32'h0,32'h10000}, 1'b0, 4'h6},
      // R8 EQ passes, carry out
      '{4'd8, 4'd0, 4'h0, {32'h2,32'h0,32'h1,32'hFFFFFFFF},
        {32'h3,32'h0,32'h1,32'h1},
        {32'h5,32'h0,32'h2,32'h0}, 1'b1, 4'h6},
      // R8 never
      '{4'd8, 4'd0, 4'hF, {4{32'h1}}, {4{32'h1}},
        {32'h5,32'h0,32'h2,32'h0}, 1'b0, 4'h6},
      // R10 reserved opcode
      '{4'd10, 4'hF, 4'hE, {4{32'h1}}, {4{32'h1}},
        {32'h5,32'h0,32'h2,32'h0}, 1'b0, 4'h6},
      // R3 CS passes: C, Z, V all set
      '{4'd3, 4'd0, 4'h2, {32'h0,32'h0,32'h1,32'h80000000},
        {32'h0,32'h0,32'h2,32'h80000000},
        {32'h0,32'h0,32'h3,32'h0}, 1'b1, 4'h7},
      // R9 VC fails
      '{4'd9, 4'd1, 4'h7, {4{32'h9}}, {4{32'h1}},
        {32'h0,32'h0,32'h3,32'h0}, 1'b0, 4'h7},
      // R8 GE fails (N!=V)
      '{4'd8, 4'd1, 4'hA, {4{32'h9}}, {4{32'h1}},
        {32'h0,32'h0,32'h3,32'h0}, 1'b0, 4'h7},
      // R8 LT passes
      '{4'd8, 4'd1, 4'hB, {32'h0,32'h0,32'h0,32'h80000000},
        {32'h0,32'h0,32'h0,32'h1},
        {32'h0,32'h0,32'h0,32'h7FFFFFFF}, 1'b1, 4'h3},
      // R10 compare under HI leaves flags
      '{4'd10, 4'd6, 4'h8, {32'h0,32'h0,32'h0,32'h1},
        {32'h0,32'h0,32'h0,32'h2},
        {32'h0,32'h0,32'h0,32'h10000}, 1'b1, 4'h3}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [3:0]   op_code = '0;
   logic [3:0]   op_cond = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         res_valid, res_wr;
   logic [127:0] res_data;
   logic [3:0]   flags;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   negsel_simd_alu dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_cond(op_cond), .src_a(src_a), .src_b(src_b),
      .res_valid(res_valid), .res_wr(res_wr), .res_data(res_data), .flags(flags)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {123'b0, flags, res_valid}, '0);
      check("R1", res_data, '0);
      check("R1", {127'b0, res_wr}, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         op_valid = 1'b1;
         op_code  = TBL[i].op;
         op_cond  = TBL[i].cond;
         src_a    = TBL[i].a;
         src_b    = TBL[i].b;
         @(posedge clk);
         @(negedge clk);
         check($sformatf("R%0d vec%0d data", TBL[i].req, i), res_data, TBL[i].exp);
         check($sformatf("R%0d vec%0d wr", TBL[i].req, i), {127'b0, res_wr}, {127'b0, TBL[i].wr});
         check($sformatf("R%0d vec%0d flags", TBL[i].req, i), {124'b0, flags}, {124'b0, TBL[i].fl});
         check($sformatf("R2 vec%0d valid", i), {127'b0, res_valid}, 128'd1);
      end

      // R9 idle cycle: no valid, no write, data held
      op_valid = 1'b0;
      op_code  = 4'd0;
      op_cond  = 4'hE;
      src_a    = {4{32'h55}};
      @(posedge clk);
      @(negedge clk);
      check("R9 idle", {126'b0, res_valid, res_wr}, '0);
      check("R9 idle data", res_data, {32'h0,32'h0,32'h0,32'h10000});

      // R1 reset mid-run
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 rerst", {124'b0, flags}, '0);
      check("R1 rerst data", res_data, '0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule